// File: doc/BRIEF.md
# ADC Oversampling Accumulator Controller

This block sits between a 12-bit sample source and the logic that consumes conversion results. A start trigger begins a regular oversampling run. The block then asks for conversions, adds up a programmable number of samples, shifts the sum right by a programmable amount, and presents one 16-bit result with a single-cycle valid strobe. Samples that arrive while the injected-sequence input is high belong to a second, injected path. That path has its own accumulator and its own enable, and it shares the sample-count and shift settings with the regular path.

An injected sequence can interrupt a regular run. One mode keeps the partial regular sum and the sample count and carries on where the run stopped. The other mode throws the partial sum away and starts the run again from its first sample. A second mode bit decides whether one trigger covers a whole run or whether every sample needs its own trigger. Configuration can only be changed while neither a regular run nor an injected sequence is in progress.

Top module: `adc_ovs_ctrl`

## Requirements
- R1: With regular oversampling enabled, ratio code c (0..7) makes a run sum exactly 2^(c+1) samples. `reg_res` carries bits [15:0] of (sum >> shift), and `reg_res_valid` is high for the one cycle after the last sample is accepted, never earlier in the run.
- R2: Shift code s (0..8) shifts the 20-bit sum right by s bits. A write whose shift code is 9..15 leaves the stored shift unchanged, and the other fields of that write still take effect.
- R3: With a path's enable clear, every sample accepted on that path produces a result on its own, equal to the zero-extended sample, with no shift applied.
- R4: With per-sample triggering off, one trigger keeps `conv_req` high until the last sample of the run. Triggers that arrive during a run start nothing more, and `busy` falls after the result.
- R5: With per-sample triggering on, `conv_req` drops after each accepted sample and rises again only after a new `start_trig` pulse.
- R6: Once `conv_req` is high it stays high until `smp_valid` is seen, unless `inj_active` is high. While `inj_active` is high, `conv_req` is low.
- R7: In pause mode (`cfg_resume` = 0), an injected sequence keeps the partial regular sum and count. The run finishes after the samples that remain, and its result includes the samples taken before the pause.
- R8: In restart mode (`cfg_resume` = 1), an injected sequence clears the partial regular sum and count. After it ends, the run needs a full set of new samples, and samples taken before the interruption are excluded.
- R9: Samples with `smp_valid` high while `inj_active` is high go to the injected accumulator, which uses the same ratio and shift. Its result appears on `inj_res` and `inj_res_valid`. It is emptied whenever `inj_active` is low, and it never disturbs the regular result.
- R10: Configuration writes made while `busy` is high (a regular run is in progress or `inj_active` is high) are ignored.
- R11: After reset, `conv_req`, `busy` and both valids are low, and the configuration is all zero: both paths disabled, ratio code 0, shift 0, per-sample triggering off, pause mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_reg_en | input | 1 | Regular oversampling enable |
| cfg_inj_en | input | 1 | Injected oversampling enable |
| cfg_ratio | input | 3 | Ratio code, 2^(code+1) samples |
| cfg_shift | input | 4 | Right shift 0..8, 9..15 reserved |
| cfg_trig_each | input | 1 | 1: each sample needs its own trigger |
| cfg_resume | input | 1 | 1: injected sequence restarts the regular run |
| start_trig | input | 1 | Regular start trigger pulse |
| inj_active | input | 1 | Injected sequence in progress |
| conv_req | output | 1 | Regular conversion request |
| smp_valid | input | 1 | Sample present on smp_data |
| smp_data | input | 12 | Sample value |
| reg_res_valid | output | 1 | Regular result strobe |
| reg_res | output | 16 | Regular result |
| inj_res_valid | output | 1 | Injected result strobe |
| inj_res | output | 16 | Injected result |
| busy | output | 1 | Regular run or injected sequence in progress |

## Verification
A regular sample is accepted at the rising edge where `conv_req` and `smp_valid` are both high. If it is the last sample of the run, `reg_res_valid` and `reg_res` are due in the cycle right after that edge, and the injected outputs follow the same one-register rule. `conv_req` rises one cycle after the triggering edge and reacts to `inj_active` within the same cycle. A configuration write acts at the next edge. The bench drives every input on the falling edge and samples outputs on the falling edge that follows the accepting rising edge. It also checks that no valid appears at any earlier sample, so a result that arrives a cycle early or late is reported.

// File: rtl/adc_ovs_pkg.sv
package adc_ovs_pkg;
  parameter int SMP_W     = 12;
  parameter int RATIO_W   = 3;
  parameter int SHIFT_W   = 4;
  parameter int MAX_SHIFT = 8;
  parameter int RES_W     = 16;
  parameter int NPATH     = 2;
  // largest ratio is 2**(2**RATIO_W) samples
  localparam int CNT_W    = 2**RATIO_W;
  localparam int ACC_W    = SMP_W + CNT_W;
  localparam int MAX_CODE = 2**RATIO_W - 1;

  typedef struct packed {
    logic               reg_en;
    logic               inj_en;
    logic               trig_each;
    logic               resume;
    logic [RATIO_W-1:0] ratio;
    logic [SHIFT_W-1:0] shift;
  } ovs_cfg_t;

  typedef enum logic {RG_IDLE, RG_RUN} rg_state_e;
endpackage

// File: rtl/ovs_cfg_reg.sv
module ovs_cfg_reg
  import adc_ovs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  logic     busy,
  input  ovs_cfg_t wdata,
  output ovs_cfg_t cfg_q
);
  ovs_cfg_t cfg_d;
  logic     cfg_ld;

  assign cfg_ld = we & ~busy;

  always_comb begin
    cfg_d = wdata;
    if (wdata.shift > SHIFT_W'(MAX_SHIFT)) cfg_d.shift = cfg_q.shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_ld) cfg_q <= cfg_d;
  end

  assert_shift_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.shift <= SHIFT_W'(MAX_SHIFT));

  assert_cfg_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_q));
endmodule

// File: rtl/ovs_accum.sv
module ovs_accum
  import adc_ovs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               smp_en,
  input  logic [SMP_W-1:0]   smp,
  input  logic               ovs_en,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [SHIFT_W-1:0] shift,
  output logic               done,
  output logic               res_vld,
  output logic [RES_W-1:0]   res
);
  logic [ACC_W-1:0] acc_q, acc_d, sum, shifted;
  logic [CNT_W-1:0] cnt_q, cnt_d, last;
  logic [RES_W-1:0] res_d;

  assign last    = {CNT_W{1'b1}} >> (RATIO_W'(MAX_CODE) - ratio);
  assign sum     = acc_q + ACC_W'(smp);
  assign shifted = sum >> shift;
  assign done    = smp_en & ~clr & (~ovs_en | (cnt_q == last));
  assign res_d   = ovs_en ? shifted[RES_W-1:0] : RES_W'(smp);

  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (clr || done) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (smp_en) begin
      acc_d = sum;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      res_vld <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      cnt_q   <= cnt_d;
      res_vld <= done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    res <= '0;
    else if (done) res <= res_d;
  end

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);

  assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en && !ovs_en && !clr |=> res_vld && (res == RES_W'($past(smp))));

  assert_clr_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0) && (cnt_q == '0));
endmodule

// File: rtl/adc_ovs_ctrl.sv
module adc_ovs_ctrl
  import adc_ovs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_reg_en,
  input  logic               cfg_inj_en,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic               cfg_trig_each,
  input  logic               cfg_resume,
  input  logic               start_trig,
  input  logic               inj_active,
  output logic               conv_req,
  input  logic               smp_valid,
  input  logic [SMP_W-1:0]   smp_data,
  output logic               reg_res_valid,
  output logic [RES_W-1:0]   reg_res,
  output logic               inj_res_valid,
  output logic [RES_W-1:0]   inj_res,
  output logic               busy
);
  logic      [1:0] rst_sync_q;
  logic            rst_ni;
  ovs_cfg_t        wdata, cfg_q;
  rg_state_e       st_q, st_d;
  logic            armed_q, armed_d, reg_take;
  logic [NPATH-1:0] p_clr, p_en, p_ovs, p_done, p_vld;
  logic [RES_W-1:0] p_res [NPATH];

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign wdata = '{reg_en: cfg_reg_en, inj_en: cfg_inj_en, trig_each: cfg_trig_each,
                   resume: cfg_resume, ratio: cfg_ratio, shift: cfg_shift};

  ovs_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_ni), .we(cfg_we), .busy(busy), .wdata(wdata), .cfg_q(cfg_q)
  );

  assign busy     = (st_q == RG_RUN) | inj_active;
  assign conv_req = (st_q == RG_RUN) & ~inj_active & (armed_q | ~cfg_q.trig_each);
  assign reg_take = conv_req & smp_valid;

  always_comb begin
    st_d    = st_q;
    armed_d = armed_q;
    case (st_q)
      RG_IDLE: if (start_trig) begin
        st_d    = RG_RUN;
        armed_d = 1'b1;
      end
      default: begin
        if (p_done[0]) begin
          st_d    = RG_IDLE;
          armed_d = 1'b0;
        end else begin
          if (reg_take && cfg_q.trig_each) armed_d = 1'b0;
          if (start_trig)                  armed_d = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RG_IDLE;
      armed_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      armed_q <= armed_d;
    end
  end

  // path 0: regular, path 1: injected
  assign p_en[0]  = reg_take;
  assign p_clr[0] = inj_active & cfg_q.resume;
  assign p_ovs[0] = cfg_q.reg_en;
  assign p_en[1]  = inj_active & smp_valid;
  assign p_clr[1] = ~inj_active;
  assign p_ovs[1] = cfg_q.inj_en;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    ovs_accum u_acc (
      .clk(clk), .rst_n(rst_ni), .clr(p_clr[p]), .smp_en(p_en[p]), .smp(smp_data),
      .ovs_en(p_ovs[p]), .ratio(cfg_q.ratio), .shift(cfg_q.shift),
      .done(p_done[p]), .res_vld(p_vld[p]), .res(p_res[p])
    );
  end

  assign reg_res_valid = p_vld[0];
  assign reg_res       = p_res[0];
  assign inj_res_valid = p_vld[1];
  assign inj_res       = p_res[1];

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    conv_req && !smp_valid |=> conv_req || inj_active);

  assert_trig_each_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    cfg_q.trig_each && reg_take && !start_trig |=> !conv_req);

  assert_inj_source_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    inj_res_valid |-> $past(inj_active));
endmodule

// File: tb/adc_ovs_ctrl_tb_top.sv
module adc_ovs_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_reg_en, cfg_inj_en, cfg_trig_each, cfg_resume;
  logic [2:0]  cfg_ratio;
  logic [3:0]  cfg_shift;
  logic        start_trig, inj_active, smp_valid;
  logic [11:0] smp_data;
  logic        conv_req, reg_res_valid, inj_res_valid, busy;
  logic [15:0] reg_res, inj_res;

  int     n_vec = 0, n_bad = 0;
  bit     finished = 0;
  longint exp_sum;
  logic        last_vld;
  logic [15:0] last_res;

  always #2 clk = ~clk;

  adc_ovs_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_reg_en(cfg_reg_en),
    .cfg_inj_en(cfg_inj_en), .cfg_ratio(cfg_ratio), .cfg_shift(cfg_shift),
    .cfg_trig_each(cfg_trig_each), .cfg_resume(cfg_resume), .start_trig(start_trig),
    .inj_active(inj_active), .conv_req(conv_req), .smp_valid(smp_valid),
    .smp_data(smp_data), .reg_res_valid(reg_res_valid), .reg_res(reg_res),
    .inj_res_valid(inj_res_valid), .inj_res(inj_res), .busy(busy)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] pat(input int seed, input int i);
    if (seed == 0) return 12'hFFF;
    return 12'((seed * 613 + i * 1021) % 4096);
  endfunction

  function automatic logic [15:0] expv(input longint s, input int sh);
    return 16'(s >> sh);
  endfunction

  task automatic write_cfg(input bit re, input bit ie, input int ra, input int sh,
                           input bit te, input bit rs);
    @(negedge clk);
    cfg_we = 1; cfg_reg_en = re; cfg_inj_en = ie; cfg_ratio = 3'(ra);
    cfg_shift = 4'(sh); cfg_trig_each = te; cfg_resume = rs;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); start_trig = 1;
    @(negedge clk); start_trig = 0;
  endtask

  task automatic serve(input logic [11:0] d, output logic vld, output logic [15:0] res,
                       output logic req_after);
    int w = 0;
    @(negedge clk);
    while (!conv_req && w < 64) begin @(negedge clk); w++; end
    if (!conv_req) check("R6 conv_req wait", 32'(conv_req), 1);
    smp_valid = 1; smp_data = d;
    @(posedge clk);
    @(negedge clk);
    smp_valid = 0;
    vld = reg_res_valid; res = reg_res; req_after = conv_req;
  endtask

  task automatic feed(input int n, input int seed, input bit fin, input bit b2b,
                      input string tag);
    logic v, ra; logic [15:0] r; logic [11:0] d;
    for (int i = 0; i < n; i++) begin
      d = pat(seed, i);
      serve(d, v, r, ra);
      exp_sum += d;
      if (fin && i == n - 1) begin
        last_vld = v; last_res = r;
      end else begin
        check({tag, " no early valid"}, 32'(v), 0);
        if (b2b) check("R4 back-to-back request", 32'(ra), 1);
      end
    end
  endtask

  task automatic inj_sample(input logic [11:0] d, output logic iv, output logic [15:0] ir,
                            output logic rv);
    @(negedge clk);
    smp_valid = 1; smp_data = d;
    @(posedge clk);
    @(negedge clk);
    smp_valid = 0;
    iv = inj_res_valid; ir = inj_res; rv = reg_res_valid;
  endtask

  task automatic run_and_check(input int n, input int seed, input int sh, input string tag);
    exp_sum = 0;
    pulse_trig();
    feed(n, seed, 1, 1, tag);
    check({tag, " valid"}, 32'(last_vld), 1);
    check({tag, " value"}, 32'(last_res), 32'(expv(exp_sum, sh)));
  endtask

  task automatic t_reset();
    check("R11 conv_req", 32'(conv_req), 0);
    check("R11 busy", 32'(busy), 0);
    check("R11 reg valid", 32'(reg_res_valid), 0);
    check("R11 inj valid", 32'(inj_res_valid), 0);
    run_and_check(1, 5, 0, "R11 default pass-through");
  endtask

  task automatic t_ratio();
    write_cfg(1, 0, 0, 0, 0, 0); run_and_check(2, 3, 0, "R1 ratio0");
    write_cfg(1, 0, 3, 2, 0, 0); run_and_check(16, 7, 2, "R1 ratio3 shift2");
    write_cfg(1, 0, 7, 4, 0, 0); run_and_check(256, 0, 4, "R1 ratio7 fullscale");
    check("R1 fullscale >>4", 32'(last_res), 65520);
    write_cfg(1, 0, 7, 0, 0, 0); run_and_check(256, 0, 0, "R1 ratio7 truncate");
    check("R1 truncated", 32'(last_res), 65280);
  endtask

  task automatic t_shift();
    write_cfg(1, 0, 2, 8, 0, 0); run_and_check(8, 0, 8, "R2 shift8");
    check("R2 shift8 value", 32'(last_res), 127);
    write_cfg(1, 0, 1, 13, 0, 0); run_and_check(4, 9, 8, "R2 reserved shift kept");
  endtask

  task automatic t_passthru();
    write_cfg(0, 0, 3, 3, 0, 0);
    run_and_check(1, 11, 0, "R3 pass-through a");
    run_and_check(1, 12, 0, "R3 pass-through b");
  endtask

  task automatic t_ignore_trig();
    write_cfg(1, 0, 1, 0, 0, 0);
    exp_sum = 0;
    pulse_trig();
    feed(2, 13, 0, 1, "R4");
    pulse_trig();
    feed(2, 14, 1, 1, "R4");
    check("R4 valid", 32'(last_vld), 1);
    check("R4 value", 32'(last_res), 32'(expv(exp_sum, 0)));
    repeat (4) begin
      @(negedge clk);
      check("R4 no second run busy", 32'(busy), 0);
      check("R4 no second run req", 32'(conv_req), 0);
    end
  endtask

  task automatic t_trig_each();
    logic v, ra; logic [15:0] r; logic [11:0] d;
    write_cfg(1, 0, 1, 1, 1, 0);
    exp_sum = 0;
    for (int i = 0; i < 4; i++) begin
      pulse_trig();
      d = pat(15, i);
      serve(d, v, r, ra);
      exp_sum += d;
      if (i < 3) begin
        check("R5 request drops", 32'(ra), 0);
        repeat (3) @(negedge clk);
        check("R5 waits for trigger", 32'(conv_req), 0);
        check("R5 no early valid", 32'(v), 0);
      end else begin
        check("R5 valid", 32'(v), 1);
        check("R5 value", 32'(r), 32'(expv(exp_sum, 1)));
      end
    end
  endtask

  task automatic t_continued();
    write_cfg(1, 0, 2, 0, 0, 0);
    exp_sum = 0;
    pulse_trig();
    feed(3, 17, 0, 1, "R7");
    repeat (3) @(negedge clk);
    check("R6 request held", 32'(conv_req), 1);
    inj_active = 1;
    repeat (5) begin
      @(negedge clk);
      check("R6 no request during injected", 32'(conv_req), 0);
      check("R7 no result during pause", 32'(reg_res_valid), 0);
    end
    inj_active = 0;
    feed(5, 18, 1, 1, "R7");
    check("R7 valid", 32'(last_vld), 1);
    check("R7 kept partial", 32'(last_res), 32'(expv(exp_sum, 0)));
  endtask

  task automatic t_resumed();
    write_cfg(1, 0, 2, 0, 0, 1);
    exp_sum = 0;
    pulse_trig();
    feed(3, 19, 0, 1, "R8");
    @(negedge clk); inj_active = 1;
    repeat (4) @(negedge clk);
    inj_active = 0;
    exp_sum = 0;
    feed(8, 20, 1, 1, "R8 restart");
    check("R8 valid", 32'(last_vld), 1);
    check("R8 fresh sum", 32'(last_res), 32'(expv(exp_sum, 0)));
  endtask

  task automatic t_injected();
    logic iv, rv; logic [15:0] ir; logic [11:0] d; longint isum = 0; longint rsum;
    write_cfg(1, 1, 1, 1, 0, 0);
    exp_sum = 0;
    pulse_trig();
    feed(2, 21, 0, 1, "R9 regular");
    rsum = exp_sum;
    @(negedge clk); inj_active = 1;
    for (int i = 0; i < 4; i++) begin
      d = pat(22, i);
      isum += d;
      inj_sample(d, iv, ir, rv);
      check("R9 regular untouched", 32'(rv), 0);
      if (i < 3) check("R9 no early inj valid", 32'(iv), 0);
      else begin
        check("R9 inj valid", 32'(iv), 1);
        check("R9 inj value", 32'(ir), 32'(expv(isum, 1)));
      end
    end
    @(negedge clk); inj_active = 0;
    exp_sum = rsum;
    feed(2, 23, 1, 1, "R9 regular");
    check("R9 regular valid", 32'(last_vld), 1);
    check("R9 regular value", 32'(last_res), 32'(expv(exp_sum, 1)));
    write_cfg(1, 0, 1, 1, 0, 0);
    @(negedge clk); inj_active = 1;
    for (int i = 0; i < 2; i++) begin
      d = pat(24, i);
      inj_sample(d, iv, ir, rv);
      check("R3 inj pass-through valid", 32'(iv), 1);
      check("R3 inj pass-through value", 32'(ir), 32'(d));
    end
    @(negedge clk); inj_active = 0;
  endtask

  task automatic t_lock();
    write_cfg(1, 0, 1, 0, 0, 0);
    exp_sum = 0;
    pulse_trig();
    feed(1, 25, 0, 1, "R10");
    write_cfg(1, 0, 3, 2, 0, 0);
    feed(3, 26, 1, 1, "R10");
    check("R10 run kept ratio", 32'(last_vld), 1);
    check("R10 run kept shift", 32'(last_res), 32'(expv(exp_sum, 0)));
    @(negedge clk); inj_active = 1;
    write_cfg(1, 0, 0, 3, 0, 0);
    @(negedge clk); inj_active = 0;
    run_and_check(4, 27, 0, "R10 write during injected ignored");
    write_cfg(1, 0, 0, 3, 0, 0);
    run_and_check(2, 28, 3, "R10 idle write applied");
  endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_reg_en = 0; cfg_inj_en = 0; cfg_ratio = 0;
    cfg_shift = 0; cfg_trig_each = 0; cfg_resume = 0; start_trig = 0;
    inj_active = 0; smp_valid = 0; smp_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ratio();
    t_shift();
    t_passthru();
    t_ignore_trig();
    t_trig_each();
    t_continued();
    t_resumed();
    t_injected();
    t_lock();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule